// File: doc/BRIEF.md
# Radar Result Stream Packer

This block takes three kinds of radar processing results and turns them into one byte stream for a host link. The three kinds are range samples, Doppler samples and detection words. Each result arrives as a data word with a single-cycle valid strobe. A 3-bit stream-select register, written by the host, chooses which kinds are forwarded.

Only a range result starts an outbound record. Doppler and detection results are kept in holding slots with sticky pending flags. The next range record picks them up if their stream is enabled and something is waiting. A record never waits on a secondary stream, so the writer cannot stall at start-up before the first Doppler or detection result exists.

The output is a byte-wide valid/ready port. Each record is framed by a header byte and a trailer byte, and a flags byte names the optional fields it carries. Reset is synchronous and active-low.

Top module: `result_stream_packer`

## Requirements
- R1: The stream-select register (`stream_sel`) is 3 bits wide and resets to 3'b001. Bit 0 enables range, bit 1 enables Doppler and bit 2 enables detection. A write on `cfg_we` takes effect at the next clock edge.
- R2: While `rst_n` is low at a clock edge, the block clears all pending flags and held values and returns the writer to idle. `tx_valid` is low in the following cycle.
- R3: A record is started only by a range result. Doppler or detection strobes alone never raise `tx_valid`.
- R4: A record is, in order: 0xAA; a flags byte; the range bytes, most significant byte first; the Doppler bytes, most significant first, if present; the detection bytes, most significant first, if present; 0x55. In the flags byte, bit 0 = 1 (range present), bit 1 = Doppler present, bit 2 = detection present, and bits 7:3 = 0.
- R5: A Doppler strobe accepted while stream bit 1 is set sets a sticky pending flag. The held value goes into the next record that starts while bit 1 is set. Starting that record clears the flag, so the following record omits the Doppler field unless a new Doppler result has arrived.
- R6: Detection results behave as in R5, using stream bit 2 and their own pending flag.
- R7: A new result arriving while its slot is still pending overwrites the held value. A strobe in the same cycle that a record takes the slot leaves the slot pending with the new value.
- R8: A strobe whose stream bit is 0 is ignored. A range strobe then produces no record, and a Doppler or detection strobe then leaves no held value behind.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged in the next cycle.
- R10: A range result arriving while a record is being sent is held as pending and is sent as the next record. Several such results collapse into one record carrying the newest value.
- R11: When the writer is idle, `tx_valid` rises in the cycle after the edge that follows the edge at which the range strobe was sampled. After a record's trailer is accepted, `tx_valid` is low for one cycle before a pending record begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Stream-select write strobe |
| cfg_data | input | 3 | Stream-select write value |
| stream_sel | output | 3 | Current stream-select value |
| rng_vld | input | 1 | Range result strobe |
| rng_data | input | RANGE_W | Range result word |
| dop_vld | input | 1 | Doppler result strobe |
| dop_data | input | DOP_W | Doppler result word |
| det_vld | input | 1 | Detection result strobe |
| det_data | input | DET_W | Detection result word |
| tx_data | output | 8 | Output byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The hardest case to reach from the ports is a pending slot being taken in the same cycle that a fresh result of that kind lands. A second hard case is a range result arriving in the very cycle the trailer is accepted. The stimulus gets there by firing all three strobes on consecutive cycles around record starts and ends, with an irregular ready pattern from an LFSR, and by a stress phase that strobes every input pseudo-randomly. A behavioural queue model predicts every output byte cycle by cycle, so any mismatch in slot hand-over or record order shows up in the cycle it happens.

// File: rtl/rsp_pkg.sv
// Package: shared types and constants for the result stream packer.
// Assumes: byte-wide output; all result widths are whole multiples of 8.
package rsp_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_FLAG,
        PH_RNG,
        PH_DOP,
        PH_DET,
        PH_TAIL
    } phase_t;

    localparam logic [7:0] HEAD_BYTE = 8'hAA;
    localparam logic [7:0] TAIL_BYTE = 8'h55;
    localparam logic [2:0] SEL_RESET = 3'b001;
endpackage

// File: rtl/rsp_sel_reg.sv
// Module: stream-select register.
// Holds the 3-bit enable mask (bit0 range, bit1 Doppler, bit2 detection).
// Assumes: synchronous active-low reset; writes land at the next edge.
module rsp_sel_reg
    import rsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_data,
    output logic [2:0] sel
);
    // Register the mask, range-only after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= SEL_RESET;
        end else if (cfg_we) begin
            sel <= cfg_data;
        end
    end

    // R1: reset value is range-only
    p_reset_value_r1: assert property (@(posedge clk) !rst_n |=> sel == SEL_RESET);
    // R1: a write is visible after one edge
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> sel == $past(cfg_data));
endmodule

// File: rtl/rsp_slot.sv
// Module: one result holding slot with a sticky pending flag.
// A strobe taken while enabled stores the word and sets the flag. A take
// from the writer clears the flag unless a new strobe lands in that cycle.
// Assumes: take is only raised while pend is set.
module rsp_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         strobe,
    input  logic [W-1:0] data,
    input  logic         take,
    output logic         pend,
    output logic [W-1:0] held
);
    // Capture newest value; a strobe wins over a take in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            held <= '0;
        end else if (strobe && en) begin
            pend <= 1'b1;
            held <= data;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    // R5: an accepted strobe leaves the slot pending with that word
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && en) |=> (pend && held == $past(data)));
    // R5: the flag is sticky until taken
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take) |=> pend);
    // R8: a disabled strobe changes nothing
    p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !en && !take) |=> ($stable(pend) && $stable(held)));
endmodule

// File: rtl/rsp_writer.sv
// Module: record writer FSM.
// Leaves idle only when a range result is pending. It snapshots the slots,
// then sends header, flags, range, optional Doppler and detection fields
// and trailer over a valid/ready byte port.
// Assumes: all widths are multiples of 8; slot values stay in the slots.
module rsp_writer
    import rsp_pkg::*;
#(
    parameter int RANGE_W = 32,
    parameter int DOP_W   = 32,
    parameter int DET_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_dop,
    input  logic               en_det,
    input  logic               rng_pend,
    input  logic [RANGE_W-1:0] rng_held,
    input  logic               dop_pend,
    input  logic [DOP_W-1:0]   dop_held,
    input  logic               det_pend,
    input  logic [DET_W-1:0]   det_held,
    output logic               take_rng,
    output logic               take_dop,
    output logic               take_det,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_valid
);
    localparam int RB   = RANGE_W / 8;
    localparam int DB   = DOP_W / 8;
    localparam int TB   = DET_W / 8;
    localparam int MAXB = (RB > DB) ? ((RB > TB) ? RB : TB) : ((DB > TB) ? DB : TB);
    localparam int CW   = $clog2(MAXB + 1);

    phase_t             phase;
    logic [CW-1:0]      left;
    logic [RANGE_W-1:0] rng_sr;
    logic [DOP_W-1:0]   dop_sr;
    logic [DET_W-1:0]   det_sr;
    logic               inc_dop;
    logic               inc_det;
    logic               acc;

    // Hand-over to the slots at the start of a record.
    always_comb begin
        take_rng = (phase == PH_IDLE) && rng_pend;
        take_dop = take_rng && dop_pend && en_dop;
        take_det = take_rng && det_pend && en_det;
    end

    assign tx_valid = (phase != PH_IDLE);
    assign acc      = tx_valid && tx_ready;

    // Choose the byte presented in the current phase.
    always_comb begin
        unique case (phase)
            PH_HEAD: tx_data = HEAD_BYTE;
            PH_FLAG: tx_data = {5'b0, inc_det, inc_dop, 1'b1};
            PH_RNG:  tx_data = rng_sr[RANGE_W-1 -: 8];
            PH_DOP:  tx_data = dop_sr[DOP_W-1 -: 8];
            PH_DET:  tx_data = det_sr[DET_W-1 -: 8];
            PH_TAIL: tx_data = TAIL_BYTE;
            default: tx_data = 8'h00;
        endcase
    end

    // Sequence phases and shift out field bytes on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            left    <= '0;
            rng_sr  <= '0;
            dop_sr  <= '0;
            det_sr  <= '0;
            inc_dop <= 1'b0;
            inc_det <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (rng_pend) begin
                        phase   <= PH_HEAD;
                        rng_sr  <= rng_held;
                        dop_sr  <= dop_held;
                        det_sr  <= det_held;
                        inc_dop <= dop_pend && en_dop;
                        inc_det <= det_pend && en_det;
                    end
                end
                PH_HEAD: if (acc) phase <= PH_FLAG;
                PH_FLAG: begin
                    if (acc) begin
                        phase <= PH_RNG;
                        left  <= CW'(RB - 1);
                    end
                end
                PH_RNG: begin
                    if (acc) begin
                        rng_sr <= rng_sr << 8;
                        if (left == '0) begin
                            if (inc_dop) begin
                                phase <= PH_DOP;
                                left  <= CW'(DB - 1);
                            end else if (inc_det) begin
                                phase <= PH_DET;
                                left  <= CW'(TB - 1);
                            end else begin
                                phase <= PH_TAIL;
                            end
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                end
                PH_DOP: begin
                    if (acc) begin
                        dop_sr <= dop_sr << 8;
                        if (left == '0) begin
                            if (inc_det) begin
                                phase <= PH_DET;
                                left  <= CW'(TB - 1);
                            end else begin
                                phase <= PH_TAIL;
                            end
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                end
                PH_DET: begin
                    if (acc) begin
                        det_sr <= det_sr << 8;
                        if (left == '0) phase <= PH_TAIL;
                        else            left  <= left - 1'b1;
                    end
                end
                PH_TAIL: if (acc) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: a stalled byte holds
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R3: without a pending range result the idle writer stays silent
    p_range_only_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !rng_pend) |=> !tx_valid);
    // R4: every record opens with the header
    p_header_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == HEAD_BYTE);
    // R4: the byte after the header is a well-formed flags byte
    p_flags_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_data == HEAD_BYTE && phase == PH_HEAD)
        |=> (tx_data[0] && tx_data[7:3] == 5'b0));
    // R11: a finished trailer returns the port to idle for one cycle
    p_gap_after_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TAIL && tx_ready) |=> !tx_valid);
endmodule

// File: rtl/result_stream_packer.sv
// Module: top of the radar result stream packer.
// Joins the stream-select register, three holding slots and the writer.
// Assumes: one clock domain; result widths are multiples of 8 bits.
module result_stream_packer #(
    parameter int RANGE_W = 32,
    parameter int DOP_W   = 32,
    parameter int DET_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_data,
    output logic [2:0]         stream_sel,
    input  logic               rng_vld,
    input  logic [RANGE_W-1:0] rng_data,
    input  logic               dop_vld,
    input  logic [DOP_W-1:0]   dop_data,
    input  logic               det_vld,
    input  logic [DET_W-1:0]   det_data,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready
);
    logic               rng_pend, dop_pend, det_pend;
    logic [RANGE_W-1:0] rng_held;
    logic [DOP_W-1:0]   dop_held;
    logic [DET_W-1:0]   det_held;
    logic               take_rng, take_dop, take_det;

    rsp_sel_reg u_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data), .sel(stream_sel)
    );

    rsp_slot #(.W(RANGE_W)) u_rng_slot (
        .clk(clk), .rst_n(rst_n), .en(stream_sel[0]), .strobe(rng_vld), .data(rng_data),
        .take(take_rng), .pend(rng_pend), .held(rng_held)
    );

    rsp_slot #(.W(DOP_W)) u_dop_slot (
        .clk(clk), .rst_n(rst_n), .en(stream_sel[1]), .strobe(dop_vld), .data(dop_data),
        .take(take_dop), .pend(dop_pend), .held(dop_held)
    );

    rsp_slot #(.W(DET_W)) u_det_slot (
        .clk(clk), .rst_n(rst_n), .en(stream_sel[2]), .strobe(det_vld), .data(det_data),
        .take(take_det), .pend(det_pend), .held(det_held)
    );

    rsp_writer #(.RANGE_W(RANGE_W), .DOP_W(DOP_W), .DET_W(DET_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .en_dop(stream_sel[1]), .en_det(stream_sel[2]),
        .rng_pend(rng_pend), .rng_held(rng_held),
        .dop_pend(dop_pend), .dop_held(dop_held),
        .det_pend(det_pend), .det_held(det_held),
        .take_rng(take_rng), .take_dop(take_dop), .take_det(take_det),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid)
    );

    // R2: reset leaves the output port idle
    p_reset_idle_r2: assert property (@(posedge clk) !rst_n |=> !tx_valid);
endmodule

// File: tb/test_result_stream_packer.sv
// Bench: behavioural queue model of the packer, compared every clock.
module test_result_stream_packer;
    localparam int RANGE_W = 32;
    localparam int DOP_W   = 32;
    localparam int DET_W   = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_data = '0;
    logic [2:0]         stream_sel;
    logic               rng_vld = 1'b0, dop_vld = 1'b0, det_vld = 1'b0;
    logic [RANGE_W-1:0] rng_data = '0;
    logic [DOP_W-1:0]   dop_data = '0;
    logic [DET_W-1:0]   det_data = '0;
    logic [7:0]         tx_data;
    logic               tx_valid;
    logic               tx_ready = 1'b1;

    result_stream_packer #(.RANGE_W(RANGE_W), .DOP_W(DOP_W), .DET_W(DET_W)) i_result_stream_packer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data), .stream_sel(stream_sel),
        .rng_vld(rng_vld), .rng_data(rng_data), .dop_vld(dop_vld), .dop_data(dop_data),
        .det_vld(det_vld), .det_data(det_data),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R2";
    int    ready_mode = 0;      // 0: always ready, 1: LFSR pattern
    logic [15:0] lfsr = 16'hACE1;
    int    seen_bytes = 0;

    // reference model state
    byte unsigned q[$];
    logic [2:0]         m_sel = 3'b001;
    bit                 m_pr = 0, m_pd = 0, m_pt = 0;
    logic [RANGE_W-1:0] m_r = '0;
    logic [DOP_W-1:0]   m_d = '0;
    logic [DET_W-1:0]   m_t = '0;

    // model update at each edge, from the inputs held since the last negedge
    always @(posedge clk) begin
        started <= 1;
        cycles  <= cycles + 1;
        if (!rst_n) begin
            q.delete();
            m_sel = 3'b001; m_pr = 0; m_pd = 0; m_pt = 0;
            m_r = '0; m_d = '0; m_t = '0;
        end else begin
            if (q.size() == 0) begin
                if (m_pr) begin
                    bit id, it;
                    id = m_pd && m_sel[1];
                    it = m_pt && m_sel[2];
                    q.push_back(8'hAA);
                    q.push_back({5'b0, it, id, 1'b1});
                    for (int i = RANGE_W/8 - 1; i >= 0; i--) q.push_back(m_r[i*8 +: 8]);
                    if (id) for (int i = DOP_W/8 - 1; i >= 0; i--) q.push_back(m_d[i*8 +: 8]);
                    if (it) for (int i = DET_W/8 - 1; i >= 0; i--) q.push_back(m_t[i*8 +: 8]);
                    q.push_back(8'h55);
                    m_pr = 0;
                    if (id) m_pd = 0;
                    if (it) m_pt = 0;
                end
            end else if (tx_ready) begin
                void'(q.pop_front());
            end
            if (rng_vld && m_sel[0]) begin m_pr = 1; m_r = rng_data; end
            if (dop_vld && m_sel[1]) begin m_pd = 1; m_d = dop_data; end
            if (det_vld && m_sel[2]) begin m_pt = 1; m_t = det_data; end
            if (cfg_we) m_sel = cfg_data;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if (tx_valid !== (q.size() != 0)) begin
                n_bad++;
                $display("FAIL %s tx_valid actual %b expected %b at cycle %0d",
                         cur_req, tx_valid, q.size() != 0, cycles);
            end else if (tx_valid && tx_data !== q[0]) begin
                n_bad++;
                $display("FAIL %s tx_data actual %02h expected %02h at cycle %0d",
                         cur_req, tx_data, q[0], cycles);
            end
            if (stream_sel !== m_sel) begin
                n_bad++;
                $display("FAIL R1 stream_sel actual %b expected %b", stream_sel, m_sel);
            end
            if (tx_valid && tx_ready) seen_bytes++;
        end
    end

    // ready pattern driver
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready <= (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired, actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_sel(input logic [2:0] v);
        @(negedge clk); cfg_we = 1; cfg_data = v;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic pulse(input bit r, input bit d, input bit t,
                         input logic [31:0] rv, input logic [31:0] dv, input logic [15:0] tv);
        @(negedge clk);
        rng_vld = r; dop_vld = d; det_vld = t;
        rng_data = rv; dop_data = dv; det_data = tv;
        @(negedge clk);
        rng_vld = 0; dop_vld = 0; det_vld = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((q.size() != 0 || m_pr) && guard < 2000) begin @(negedge clk); guard++; end
        idle(3);
    endtask

    initial begin
        // R2 / R1: reset state
        idle(3);
        cur_req = "R2";
        if (stream_sel !== 3'b001 || tx_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset sel actual %b valid %b expected 001 0", stream_sel, tx_valid);
        end
        n_vec++;
        rst_n = 1;
        idle(2);

        // R8: Doppler and detection disabled by default, range-less stream silent
        cur_req = "R8";
        pulse(0, 1, 1, 0, 32'h11112222, 16'h3333);
        idle(5);

        // R3: secondary results alone never start a record
        cur_req = "R3";
        write_sel(3'b111);
        pulse(0, 1, 0, 0, 32'hD0D0D0D1, 0);
        pulse(0, 0, 1, 0, 0, 16'hBEEF);
        idle(20);
        if (seen_bytes != 0) begin
            n_bad++;
            $display("FAIL R3 bytes actual %0d expected 0", seen_bytes);
        end
        n_vec++;

        // R4 R5 R6: full record, then a range-only record
        cur_req = "R4";
        pulse(1, 0, 0, 32'h01020304, 0, 0);
        drain();
        cur_req = "R5";
        pulse(1, 0, 0, 32'hA1B2C3D4, 0, 0);
        drain();
        cur_req = "R6";
        pulse(0, 0, 1, 0, 0, 16'h0F0E);
        pulse(1, 0, 0, 32'h55AA55AA, 0, 0);
        drain();

        // R7: newest value wins, and a strobe on the take cycle survives
        cur_req = "R7";
        pulse(0, 1, 0, 0, 32'h0000_0001, 0);
        pulse(0, 1, 0, 0, 32'h0000_0002, 0);
        @(negedge clk); rng_vld = 1; rng_data = 32'hCAFE0001;
        @(negedge clk); rng_vld = 0; dop_vld = 1; dop_data = 32'h0000_0003;
        @(negedge clk); dop_vld = 0;
        drain();
        pulse(1, 0, 0, 32'hCAFE0002, 0, 0);
        drain();

        // R11: latency from strobe to first byte with idle writer
        cur_req = "R11";
        @(negedge clk); rng_vld = 1; rng_data = 32'h12345678;
        @(negedge clk); rng_vld = 0;
        if (tx_valid !== 1'b0) begin
            n_bad++; $display("FAIL R11 early valid actual %b expected 0", tx_valid);
        end
        @(negedge clk);
        if (tx_valid !== 1'b1 || tx_data !== 8'hAA) begin
            n_bad++; $display("FAIL R11 first byte actual %b/%02h expected 1/aa", tx_valid, tx_data);
        end
        n_vec += 2;
        drain();

        // R10: range results during a record collapse to one pending record
        cur_req = "R10";
        pulse(1, 1, 1, 32'h0A0A0A0A, 32'hD1D1D1D1, 16'h7777);
        idle(3);
        pulse(1, 0, 0, 32'h0B0B0B0B, 0, 0);
        pulse(1, 0, 0, 32'h0C0C0C0C, 0, 0);
        drain();

        // R9: irregular ready
        cur_req = "R9";
        ready_mode = 1;
        for (int k = 0; k < 6; k++) begin
            pulse(1, k[0], k[1], 32'h1000 + k, 32'h2000 + k, 16'(16'h300 + k));
            idle(k * 3);
        end
        drain();

        // R8: range stream disabled, nothing sent; then Doppler disabled
        cur_req = "R8";
        write_sel(3'b000);
        pulse(1, 1, 1, 32'hDEAD0000, 32'hDEAD0001, 16'hDEAD);
        idle(10);
        write_sel(3'b101);
        pulse(0, 1, 0, 0, 32'h99999999, 0);
        pulse(1, 0, 1, 32'hFACE0000, 0, 16'h4242);
        drain();

        // R2: reset in the middle of a record
        cur_req = "R2";
        write_sel(3'b111);
        pulse(1, 1, 0, 32'h77777777, 32'h88888888, 0);
        idle(4);
        @(negedge clk); rst_n = 0;
        idle(2);
        rst_n = 1;
        idle(3);
        pulse(1, 0, 0, 32'h0BADF00D, 0, 0);
        drain();

        // stress: pseudo-random strobes, ready and writes (R5 R6 R7 R10)
        cur_req = "R10";
        write_sel(3'b111);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            rng_vld  = (lfsr[2:0] == 3'd1);
            dop_vld  = lfsr[5] & lfsr[7];
            det_vld  = lfsr[9] & lfsr[11];
            rng_data = {lfsr, ~lfsr};
            dop_data = {~lfsr, lfsr};
            det_data = lfsr ^ 16'h5A5A;
            cfg_we   = (k % 700 == 350);
            cfg_data = lfsr[4:2] | 3'b001;
        end
        @(negedge clk);
        rng_vld = 0; dop_vld = 0; det_vld = 0; cfg_we = 0;
        ready_mode = 0;
        drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule